// File: doc/BRIEF.md
# Flash Page-Buffer Write Controller

The block collects byte writes into a 128-entry page buffer and then commits the whole buffer to a behavioural flash array in one operation. While the buffer-map input is high, every data write lands in the buffer at the entry picked by the low seven address bits, and that entry is marked as loaded. Bytes may arrive in any order and may be overwritten. While the map input is low, writes pass through to the ordinary data space, which is shown by a strobe.

A commit is started by two writes to the control key input. The first carries key nibble 0x5 and the second carries key nibble 0xA. The destination page is taken from the address of the most recent buffer write. If that address lies in the upper half of the address space, the bank-select value present at that write is also used. A commit erases the destination page to 0xFF and then programs only the loaded bytes. The block raises `busy` for the length of the erase and program phases, which are set by parameters. If a commit is started with nothing loaded, no operation runs and a sequence-error flag is set instead.

Top module: `pgbuf_writer`

## Requirements
- R1: With `map_en`=1 and `busy`=0, a write stores `wr_data` in buffer entry `wr_addr[6:0]` and marks that entry as loaded. Writes may come in any order, and a later write to the same entry replaces the earlier byte.
- R2: With `map_en`=0, `ds_we` equals `wr_en` in the same cycle and the buffer is not changed. With `map_en`=1, `ds_we` is 0.
- R3: The destination page comes from the last accepted buffer write. With address bits [8] and [7] named h and p, the physical page is p when h=0, and 2 + 2*bank + p when h=1, where bank is `bank_sel` at that write. With h=0 the bank value is ignored.
- R4: A commit starts only when a control write with `ctl_key`=0x5 is followed by a control write with `ctl_key`=0xA. Any other control write in between cancels the pending key, and an 0xA key with no 0x5 key before it does nothing.
- R5: If the key pair arrives with no entry loaded, `busy` stays 0 and `seq_err` becomes 1.
- R6: An accepted commit raises `busy` at the clock edge that takes the 0xA key. `busy` then stays high for exactly ERASE_CYC+PROG_CYC cycles, and `seq_err` is cleared.
- R7: After a commit, the loaded entries of the destination page hold their buffered bytes, the unloaded entries read 0xFF even if they held other data before, and every other page is unchanged.
- R8: While `busy` is high, buffer writes (data and captured address), `buf_clr` pulses and control writes are all ignored.
- R9: A `buf_clr` pulse while idle clears every loaded mark and clears `seq_err`.
- R10: The buffer is emptied when `busy` falls, so a key pair given right after a commit is refused as in R5.
- R11: After reset, `busy`, `seq_err` and `ds_we` are 0 and every byte of the array reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Data write strobe |
| wr_addr | input | ADDR_W | Data write address |
| wr_data | input | 8 | Data write byte |
| map_en | input | 1 | Sends data writes to the page buffer |
| bank_sel | input | BANK_W | Bank for upper-half pages |
| ds_we | output | 1 | Write passed to ordinary data space |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_key | input | 4 | Upper nibble of the control write value |
| buf_clr | input | 1 | Clears the loaded marks |
| busy | output | 1 | Erase or program in progress |
| seq_err | output | 1 | Commit refused on an empty buffer |
| obs_page | input | PG_W | Physical page to observe in the array |
| obs_ofs | input | OFS_W | Byte offset to observe |
| obs_data | output | 8 | Array byte at the observed location |

## Verification
The bench commits a page at every physical location, once for each of the eight banks in the upper half. Each buffer is loaded in a scattered order and the last write is aimed at the real page after decoy writes to another page and bank. A design that captured the first address, or that ignored the bank, would program the wrong page, and the full-array comparison would catch it. Each page is committed twice with different loaded sets, so a design that skipped the erase would leave old bytes where 0xFF is expected. During a busy window the bench sends stray writes, a clear pulse and a key pair. If any of these were accepted, the committed page or the busy length would change. Cancelled key pairs, a lone 0xA key, and commits of an emptied or cleared buffer all check that `busy` stays low and that `seq_err` is set and cleared as required.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ERASE, SEQ_PROG} seq_state_t;

  localparam logic [3:0] KEY_ARM  = 4'h5;
  localparam logic [3:0] KEY_FIRE = 4'hA;

  // pages reachable through the lower half of the address space
  function automatic int lower_pages(int addr_w, int ofs_w);
    return 1 << (addr_w - 1 - ofs_w);
  endfunction

  // lower-half pages plus one copy of the upper half per bank
  function automatic int total_pages(int addr_w, int ofs_w, int bank_w);
    return lower_pages(addr_w, ofs_w) * (1 + (1 << bank_w));
  endfunction

  // physical page number from captured address fields
  function automatic int phys_page(int upper, int pg_lo, int bank, int lo_pages);
    if (upper != 0) return lo_pages + bank * lo_pages + pg_lo;
    return pg_lo;
  endfunction
endpackage

// File: rtl/pgw_latches.sv
module pgw_latches #(
  parameter int ADDR_W = 9,
  parameter int OFS_W  = 7,
  parameter int BANK_W = 3,
  localparam int PB    = 1 << OFS_W,
  localparam int LO_W  = ADDR_W - 1 - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [BANK_W-1:0] bank,
  input  logic              clr,
  output logic [7:0]        lat_data [PB],
  output logic [PB-1:0]     lat_valid,
  output logic              tgt_upper,
  output logic [LO_W-1:0]   tgt_pg_lo,
  output logic [BANK_W-1:0] tgt_bank
);
  logic [OFS_W-1:0] ofs;
  assign ofs = addr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_valid <= '0;
      tgt_upper <= 1'b0;
      tgt_pg_lo <= '0;
      tgt_bank  <= '0;
      for (int i = 0; i < PB; i++) lat_data[i] <= 8'h00;
    end else if (clr) begin
      lat_valid <= '0;
    end else if (we) begin
      lat_data[ofs]  <= data;
      lat_valid[ofs] <= 1'b1;
      tgt_upper      <= addr[ADDR_W-1];
      tgt_pg_lo      <= addr[ADDR_W-2:OFS_W];
      tgt_bank       <= bank;
    end
  end
endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer
  import pgw_pkg::*;
#(
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 6,
  localparam int LONGEST  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CNT_W    = $clog2(LONGEST + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_key,
  input  logic       buf_empty,
  input  logic       clr_err,
  output logic       busy,
  output logic       seq_err,
  output logic       launch_ok,
  output logic       launch_refused,
  output logic       erase_stb,
  output logic       prog_stb
);
  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             ctl_live;
  logic             launch_try;

  assign busy           = (st != SEQ_IDLE);
  assign ctl_live       = ctl_wr && !busy;
  assign launch_try     = ctl_live && armed && (ctl_key == KEY_FIRE);
  assign launch_ok      = launch_try && !buf_empty;
  assign launch_refused = launch_try && buf_empty;
  assign erase_stb      = (st == SEQ_ERASE) && (cnt == '0);
  assign prog_stb       = (st == SEQ_PROG) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      cnt     <= '0;
      armed   <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      if (ctl_live) armed <= (ctl_key == KEY_ARM);
      if (launch_refused) seq_err <= 1'b1;
      else if (launch_ok || clr_err) seq_err <= 1'b0;
      case (st)
        SEQ_IDLE: if (launch_ok) begin
          st  <= SEQ_ERASE;
          cnt <= CNT_W'(ERASE_CYC - 1);
        end
        SEQ_ERASE: if (cnt == '0) begin
          st  <= SEQ_PROG;
          cnt <= CNT_W'(PROG_CYC - 1);
        end else cnt <= cnt - 1'b1;
        SEQ_PROG: if (cnt == '0) st <= SEQ_IDLE;
                  else cnt <= cnt - 1'b1;
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_flash_array.sv
module pgw_flash_array #(
  parameter int PAGES = 18,
  parameter int OFS_W = 7,
  localparam int PB   = 1 << OFS_W,
  localparam int PG_W = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_stb,
  input  logic             prog_stb,
  input  logic [PG_W-1:0]  tgt_page,
  input  logic [7:0]       lat_data [PB],
  input  logic [PB-1:0]    lat_valid,
  input  logic [PG_W-1:0]  obs_page,
  input  logic [OFS_W-1:0] obs_ofs,
  output logic [7:0]       obs_data
);
  logic [7:0] mem [PAGES][PB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        for (int i = 0; i < PB; i++) mem[p][i] <= 8'h00;
    end else if (erase_stb) begin
      for (int i = 0; i < PB; i++) mem[tgt_page][i] <= 8'hFF;
    end else if (prog_stb) begin
      for (int i = 0; i < PB; i++)
        if (lat_valid[i]) mem[tgt_page][i] <= lat_data[i];
    end
  end

  assign obs_data = (int'(obs_page) < PAGES) ? mem[obs_page][obs_ofs] : 8'h00;
endmodule

// File: rtl/pgbuf_writer.sv
module pgbuf_writer
  import pgw_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int OFS_W     = 7,
  parameter int BANK_W    = 3,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 6,
  localparam int PAGES    = total_pages(ADDR_W, OFS_W, BANK_W),
  localparam int PG_W     = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              map_en,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              ds_we,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_key,
  input  logic              buf_clr,
  output logic              busy,
  output logic              seq_err,
  input  logic [PG_W-1:0]   obs_page,
  input  logic [OFS_W-1:0]  obs_ofs,
  output logic [7:0]        obs_data
);
  localparam int PB       = 1 << OFS_W;
  localparam int LO_W     = ADDR_W - 1 - OFS_W;
  localparam int LO_PAGES = lower_pages(ADDR_W, OFS_W);

  // named internal events, also observed by the bound checker
  logic              latch_we, buf_clr_idle, lat_clr, buf_empty;
  logic              launch_ok, launch_refused, erase_stb, prog_stb;
  logic [7:0]        lat_data [PB];
  logic [PB-1:0]     lat_valid;
  logic              tgt_upper;
  logic [LO_W-1:0]   tgt_pg_lo;
  logic [BANK_W-1:0] tgt_bank;
  logic [PG_W-1:0]   tgt_page;

  assign ds_we        = wr_en && !map_en;
  assign latch_we     = wr_en && map_en && !busy;
  assign buf_clr_idle = buf_clr && !busy;
  assign lat_clr      = buf_clr_idle || prog_stb;
  assign buf_empty    = (lat_valid == '0);
  assign tgt_page     = PG_W'(phys_page(int'(tgt_upper), int'(tgt_pg_lo),
                                        int'(tgt_bank), LO_PAGES));

  pgw_latches #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BANK_W(BANK_W)) u_latches (
    .clk(clk), .rst_n(rst_n), .we(latch_we), .addr(wr_addr), .data(wr_data),
    .bank(bank_sel), .clr(lat_clr), .lat_data(lat_data), .lat_valid(lat_valid),
    .tgt_upper(tgt_upper), .tgt_pg_lo(tgt_pg_lo), .tgt_bank(tgt_bank)
  );

  pgw_sequencer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_key(ctl_key),
    .buf_empty(buf_empty), .clr_err(buf_clr_idle), .busy(busy),
    .seq_err(seq_err), .launch_ok(launch_ok), .launch_refused(launch_refused),
    .erase_stb(erase_stb), .prog_stb(prog_stb)
  );

  pgw_flash_array #(.PAGES(PAGES), .OFS_W(OFS_W)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_stb(erase_stb), .prog_stb(prog_stb),
    .tgt_page(tgt_page), .lat_data(lat_data), .lat_valid(lat_valid),
    .obs_page(obs_page), .obs_ofs(obs_ofs), .obs_data(obs_data)
  );
endmodule

// File: rtl/pgbuf_writer_chk.sv
module pgbuf_writer_chk #(
  parameter int PB = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          seq_err,
  input logic          launch_ok,
  input logic          launch_refused,
  input logic          erase_stb,
  input logic          prog_stb,
  input logic [PB-1:0] lat_valid
);
  assert_refuse_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch_refused |=> (seq_err && !busy));

  assert_launch_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ok |=> (busy && !seq_err));

  assert_one_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_stb, prog_stb}));

  assert_prog_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> (lat_valid != '0));

  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_stb) |=> $stable(lat_valid));

  assert_empty_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> (!busy && lat_valid == '0));
endmodule

bind pgbuf_writer pgbuf_writer_chk #(.PB(PB)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .seq_err(seq_err),
  .launch_ok(launch_ok), .launch_refused(launch_refused),
  .erase_stb(erase_stb), .prog_stb(prog_stb), .lat_valid(lat_valid)
);

// File: tb/pgbuf_writer_bench.sv
module pgbuf_writer_bench;
  localparam int AW    = 9;
  localparam int OW    = 7;
  localparam int BW    = 3;
  localparam int EC    = 6;
  localparam int PC    = 12;
  localparam int PB    = 128;
  localparam int HALF  = 256;
  localparam int LOP   = HALF / PB;
  localparam int NBANK = 8;
  localparam int NPG   = LOP * (1 + NBANK);
  localparam int PGW   = $clog2(NPG);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, map_en = 1'b0, ctl_wr = 1'b0, buf_clr = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [BW-1:0] bank_sel = '0;
  logic [3:0] ctl_key = '0;
  logic [PGW-1:0] obs_page = '0;
  logic [OW-1:0] obs_ofs = '0;
  logic ds_we, busy, seq_err;
  logic [7:0] obs_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_mem [NPG*PB];
  logic [7:0] m_data [PB];
  logic       m_valid [PB];
  int m_addr = 0, m_bank = 0;

  always #10 clk = ~clk;

  pgbuf_writer #(.ADDR_W(AW), .OFS_W(OW), .BANK_W(BW), .ERASE_CYC(EC),
                 .PROG_CYC(PC)) u_pgbuf_writer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .map_en(map_en), .bank_sel(bank_sel), .ds_we(ds_we),
    .ctl_wr(ctl_wr), .ctl_key(ctl_key), .buf_clr(buf_clr), .busy(busy),
    .seq_err(seq_err), .obs_page(obs_page), .obs_ofs(obs_ofs),
    .obs_data(obs_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  function automatic int page_of(int a, int b);
    if (a < HALF) return a / PB;
    return LOP + b * LOP + (a - HALF) / PB;
  endfunction

  // raw write; model is updated only when the design is idle
  task automatic raw_write(input int a, input int d, input int b, input bit m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d); bank_sel = BW'(b); map_en = m;
    @(negedge clk);
    wr_en = 1'b0; map_en = 1'b0;
  endtask

  task automatic load(input int a, input int d, input int b);
    raw_write(a, d, b, 1'b1);
    m_data[a % PB] = 8'(d);
    m_valid[a % PB] = 1'b1;
    m_addr = a;
    m_bank = b;
  endtask

  task automatic ctl(input int k);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_key = 4'(k);
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    buf_clr = 1'b1;
    @(negedge clk);
    buf_clr = 1'b0;
  endtask

  task automatic model_clear();
    for (int i = 0; i < PB; i++) m_valid[i] = 1'b0;
  endtask

  function automatic bit model_empty();
    for (int i = 0; i < PB; i++) if (m_valid[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_commit();
    int pg;
    pg = page_of(m_addr, m_bank);
    for (int i = 0; i < PB; i++)
      exp_mem[pg*PB + i] = m_valid[i] ? m_data[i] : 8'hFF;
    model_clear();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_mem(input string req);
    for (int p = 0; p < NPG; p++) begin
      int bad, bad_act, bad_exp;
      bad = -1; bad_act = 0; bad_exp = 0;
      for (int i = 0; i < PB; i++) begin
        obs_page = PGW'(p); obs_ofs = OW'(i);
        #1;
        if (bad < 0 && obs_data !== exp_mem[p*PB + i]) begin
          bad = i; bad_act = int'(obs_data); bad_exp = int'(exp_mem[p*PB + i]);
        end
      end
      chk(bad < 0, req, bad_act, bad_exp);
    end
  endtask

  // key pair plus full-length busy check (R6) and array check (R7)
  task automatic commit_and_check(input string req);
    int n;
    ctl(5);
    ctl(10);
    chk(busy === 1'b1, "R6 busy rises", int'(busy), 1);
    wait_idle(n);
    chk(n == EC + PC, "R6 busy length", n, EC + PC);
    chk(seq_err === 1'b0, "R6 seq_err cleared", int'(seq_err), 0);
    model_commit();
    check_mem(req);
  endtask

  initial begin
    int n;
    for (int i = 0; i < NPG*PB; i++) exp_mem[i] = 8'h00;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(busy === 1'b0, "R11 busy", int'(busy), 0);
    chk(seq_err === 1'b0, "R11 seq_err", int'(seq_err), 0);
    chk(ds_we === 1'b0, "R11 ds_we", int'(ds_we), 0);
    check_mem("R11 array zero");

    // R2 pass-through write goes to data space and leaves buffer empty
    @(negedge clk);
    wr_en = 1'b1; map_en = 1'b0; wr_addr = AW'(9'h013); wr_data = 8'h77;
    #1;
    chk(ds_we === 1'b1, "R2 ds_we", int'(ds_we), 1);
    map_en = 1'b1; wr_en = 1'b0;
    #1;
    chk(ds_we === 1'b0, "R2 ds_we mapped", int'(ds_we), 0);
    map_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; map_en = 1'b0;
    raw_write(9'h021, 8'h44, 0, 1'b0);
    ctl(5);
    ctl(10);
    chk(busy === 1'b0, "R2/R5 no busy on empty", int'(busy), 0);
    chk(seq_err === 1'b1, "R5 seq_err set", int'(seq_err), 1);

    // R9 clear pulse drops seq_err
    pulse_clr();
    chk(seq_err === 1'b0, "R9 seq_err cleared", int'(seq_err), 0);

    // R4 lone fire key and cancelled pair do nothing
    load(9'h005, 8'h3C, 0);
    ctl(10);
    chk(busy === 1'b0, "R4 lone fire", int'(busy), 0);
    ctl(5);
    ctl(3);
    ctl(10);
    chk(busy === 1'b0, "R4 cancelled pair", int'(busy), 0);
    chk(seq_err === 1'b0, "R4 no error", int'(seq_err), 0);
    commit_and_check("R7 first commit");

    // R10 buffer emptied after commit
    ctl(5);
    ctl(10);
    chk(busy === 1'b0, "R10 relaunch busy", int'(busy), 0);
    chk(seq_err === 1'b1, "R10 relaunch refused", int'(seq_err), 1);

    // R1 R3 R6 R7 sweep over every physical page, two passes
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < NPG; p++) begin
        int base, bank, dec, dbank, tofs;
        if (p < LOP) begin
          base = p * PB; bank = (p * 3 + 1 + pass) % NBANK;
        end else begin
          base = HALF + ((p - LOP) % LOP) * PB; bank = (p - LOP) / LOP;
        end
        dec = (base + PB) % (2 * HALF);
        dbank = (bank + 3) % NBANK;
        for (int k = 0; k < PB; k++) begin
          int ofs;
          ofs = (k * 37 + p * 11) % PB;
          if ((ofs + p + pass) % 3 != 0)
            load(dec + ofs, (ofs * 3 + p * 29 + pass * 101 + 7) % 256, dbank);
        end
        tofs = (p * 5 + pass) % PB;
        load(base + tofs, 8'h5A ^ p, bank);
        commit_and_check("R1/R3/R7 sweep");
      end
    end

    // R8 writes, clear and keys during busy are ignored
    load(9'h110, 8'hA1, 2);
    load(9'h112, 8'hA2, 2);
    ctl(5);
    ctl(10);
    chk(busy === 1'b1, "R8 busy", int'(busy), 1);
    raw_write(9'h111, 8'hEE, 2, 1'b1);
    raw_write(9'h110, 8'hDD, 2, 1'b1);
    raw_write(9'h020, 8'hCC, 6, 1'b1);
    pulse_clr();
    ctl(5);
    ctl(10);
    wait_idle(n);
    chk(busy === 1'b0, "R8 idle", int'(busy), 0);
    chk(seq_err === 1'b0, "R8 keys ignored", int'(seq_err), 0);
    model_commit();
    check_mem("R8 busy writes dropped");
    @(negedge clk);
    chk(busy === 1'b0, "R8 no second commit", int'(busy), 0);

    // R9 cleared buffer refuses a commit and leaves the array alone
    load(9'h001, 8'h11, 0);
    load(9'h002, 8'h22, 0);
    pulse_clr();
    model_clear();
    chk(model_empty(), "R9 model", 0, 0);
    ctl(5);
    ctl(10);
    chk(busy === 1'b0, "R9 no busy", int'(busy), 0);
    chk(seq_err === 1'b1, "R9 refused", int'(seq_err), 1);
    check_mem("R9 array unchanged");
    pulse_clr();
    chk(seq_err === 1'b0, "R9 err cleared", int'(seq_err), 0);

    summary();
  end
endmodule